// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single input line. A free-running strobe at sixteen times the bit rate paces it. The line first passes through a two-flop synchroniser. An idle receiver waits for a high-to-low edge on the line. It confirms the start bit half a bit period later, then samples each following bit once per bit period at its centre. It collects 5 to 8 data bits, an optional parity bit and the stop bit. Each finished character is offered downstream as one 12-bit word that carries the data together with four error flags.

Character length and parity mode come from plain configuration pins. The receiver captures them at the moment a start edge is accepted, so a change in the middle of a frame only affects the next character. The output side is a valid/ready stream that cannot stall. `word_valid` is high for exactly one cycle per character. If `word_ready` is low in that cycle, the downstream queue counts as full and the word is dropped. The next word that is accepted carries the overrun flag. The receiver never waits for space, because the serial line cannot be paused.

Top module: `uart_rx`

## Requirements
- R1: A start is recognised only on a high-to-low change of the synchronised line, seen between two successive 16x ticks while idle. A line that has stayed low since reset never starts a character.
- R2: The line is checked again on the 8th tick after the start edge. If it is high at that point, the start is discarded and no word is produced.
- R3: After a confirmed start, each further bit is sampled 16 ticks after the previous sample. The data bits are assembled least significant bit first.
- R4: `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3). Data bits above the chosen length are zero in `word_data[7:0]`.
- R5: When `cfg_par_en` is 1, one parity bit follows the data. The expected parity bit is the XOR of the data bits, inverted when `cfg_par_odd` is 1. A mismatch sets `word_data[9]`. With parity off, `word_data[9]` is 0.
- R6: A low stop bit sets the framing flag `word_data[8]`.
- R7: If the data, parity and stop bits are all low, the break flag `word_data[10]` is set, together with the framing flag. After any character, a new start needs the line to be seen high first, so a held-low line yields only one word.
- R8: The word layout is data in [7:0], framing in [8], parity in [9], break in [10] and overrun in [11]. `word_valid` is a single-cycle pulse that rises in the second clock cycle after the tick on which the stop bit is sampled.
- R9: If `word_valid` is high while `word_ready` is low, that word is discarded and an overrun becomes pending. The next accepted word has `word_data[11]` set, and an accepted word clears the pending overrun.
- R10: During and right after reset, `word_valid` is low and the receiver is idle.
- R11: The length and parity settings are captured when the start edge is accepted. Changes during a character do not affect that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | 1 = a parity bit follows the data |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| word_ready | input | 1 | Downstream queue can take a word (low = full) |
| word_valid | output | 1 | One-cycle strobe: a character word is offered |
| word_data | output | 12 | {overrun, break, parity err, framing err, data[7:0]} |

## Verification
A finished word becomes due two clock cycles after the tick that samples the stop bit. That tick falls half a bit period into the stop bit, so the bench requires each expected word to have been taken from the scoreboard by the time the stop bit it drove has ended. The monitor compares words on falling clock edges, whenever valid and ready are both high. The confirmation of a false start falls eight ticks (32 clocks) after the edge, so the bench raises the line earlier than that and then checks for two full bit periods that no word count changes. The word dropped on an overrun is checked through the flag on the next accepted word.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = 12;
  localparam int FLG_FRM = 8;
  localparam int FLG_PAR = 9;
  localparam int FLG_BRK = 10;
  localparam int FLG_OVR = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    SK_DATA,
    SK_PAR,
    SK_STOP
  } samp_kind_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/uart_rx_bitctl.sv
module uart_rx_bitctl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] cfg_len,
  input  logic       cfg_pen,
  input  logic       cfg_podd,
  output logic       samp_stb,
  output samp_kind_e samp_kind,
  output logic       samp_bit,
  output logic [1:0] len_q,
  output logic       pen_q,
  output logic       podd_q
);
  localparam int CNT_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitn;
  logic             prev_hi;
  logic [2:0]       last_bit;

  assign last_bit = 3'd4 + {1'b0, len_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      prev_hi   <= 1'b0;
      len_q     <= 2'd3;
      pen_q     <= 1'b0;
      podd_q    <= 1'b0;
      samp_stb  <= 1'b0;
      samp_kind <= SK_DATA;
      samp_bit  <= 1'b0;
    end else begin
      samp_stb <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            prev_hi <= rx;
            if (prev_hi && !rx) begin
              state  <= ST_START;
              cnt    <= '0;
              len_q  <= cfg_len;
              pen_q  <= cfg_pen;
              podd_q <= cfg_podd;
            end
          end
          ST_START: begin
            if (cnt == CNT_HALF) begin
              cnt  <= '0;
              bitn <= '0;
              if (rx) begin
                state   <= ST_IDLE;
                prev_hi <= 1'b1;
              end else begin
                state <= ST_DATA;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA, ST_PAR, ST_STOP: begin
            if (cnt == CNT_FULL) begin
              cnt      <= '0;
              samp_stb <= 1'b1;
              samp_bit <= rx;
              if (state == ST_DATA) begin
                samp_kind <= SK_DATA;
                if (bitn == last_bit) state <= pen_q ? ST_PAR : ST_STOP;
                else                  bitn  <= bitn + 1'b1;
              end else if (state == ST_PAR) begin
                samp_kind <= SK_PAR;
                state     <= ST_STOP;
              end else begin
                samp_kind <= SK_STOP;
                state     <= ST_IDLE;
                prev_hi   <= rx;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_stb,
  input  samp_kind_e        samp_kind,
  input  logic              samp_bit,
  input  logic [1:0]        len_q,
  input  logic              podd_q,
  input  logic              word_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              ovr_pend
);
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] aligned;
  logic              par_err;
  logic              any_one;
  logic              par_exp;
  logic              brk;

  assign aligned = shreg >> (2'd3 - len_q);
  assign par_exp = (^aligned) ^ podd_q;
  assign brk     = !any_one && !samp_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      par_err    <= 1'b0;
      any_one    <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      ovr_pend   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (word_valid) ovr_pend <= !word_ready;
      if (samp_stb) begin
        unique case (samp_kind)
          SK_DATA: begin
            shreg   <= {samp_bit, shreg[DATA_W-1:1]};
            any_one <= any_one | samp_bit;
          end
          SK_PAR: begin
            par_err <= (samp_bit != par_exp);
            any_one <= any_one | samp_bit;
          end
          SK_STOP: begin
            word_valid <= 1'b1;
            word_data  <= {ovr_pend, brk, par_err, !samp_bit, aligned};
            shreg      <= '0;
            par_err    <= 1'b0;
            any_one    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_in,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        word_ready,
  output logic        word_valid,
  output logic [11:0] word_data
);
  logic       rx_s;
  logic       samp_stb;
  samp_kind_e samp_kind;
  logic       samp_bit;
  logic [1:0] len_q;
  logic       pen_q;
  logic       podd_q;
  logic       ovr_pend;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  uart_rx_bitctl #(.OVS(OVS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
    .cfg_len(cfg_len), .cfg_pen(cfg_par_en), .cfg_podd(cfg_par_odd),
    .samp_stb(samp_stb), .samp_kind(samp_kind), .samp_bit(samp_bit),
    .len_q(len_q), .pen_q(pen_q), .podd_q(podd_q)
  );

  uart_rx_frame u_frm (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .samp_kind(samp_kind),
    .samp_bit(samp_bit), .len_q(len_q), .podd_q(podd_q),
    .word_ready(word_ready), .word_valid(word_valid), .word_data(word_data),
    .ovr_pend(ovr_pend)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
  import uart_rx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        word_ready,
  input logic [11:0] word_data,
  input logic        samp_stb,
  input samp_kind_e  samp_kind,
  input logic [1:0]  len_q,
  input logic        pen_q,
  input logic        ovr_pend
);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_valid_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_stb && samp_kind == SK_STOP) |=> word_valid);

  assert_break_framing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_data[FLG_BRK]) |-> (word_data[FLG_FRM] && word_data[7:0] == 8'h00));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ((word_data[7:0] >> (4'd5 + {2'b00, len_q})) == 8'h00));

  assert_no_par_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !pen_q) |-> !word_data[FLG_PAR]);

  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> ovr_pend);

  assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> !ovr_pend);
endmodule

bind uart_rx uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .samp_stb(samp_stb), .samp_kind(samp_kind),
  .len_q(len_q), .pen_q(pen_q), .ovr_pend(ovr_pend)
);

// File: tb/uart_rx_tb.sv
module uart_rx_tb;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b0;
  logic        rx_in = 1'b0;
  logic [1:0]  cfg_len = 2'd3;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic        word_ready = 1'b1;
  logic        word_valid;
  logic [11:0] word_data;

  int checks = 0;
  int fails = 0;
  int n_words = 0;
  int tdiv = 0;
  bit bench_ovr = 1'b0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  logic [11:0] mon_e;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (tdiv == TDIV - 1) begin tdiv <= 0; tick16 <= 1'b1; end
    else begin tdiv <= tdiv + 1; tick16 <= 1'b0; end
  end

  uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .word_ready(word_ready), .word_valid(word_valid), .word_data(word_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor (R8 word layout, R9 accepted words only)
  always @(negedge clk) begin
    if (rst_n && word_valid && word_ready) begin
      n_words++;
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected word", int'(word_data), 0);
      else begin
        mon_e = exp_q.pop_front();
        chk(word_data == mon_e, "R8", "word contents", int'(word_data), int'(mon_e));
      end
    end
  end

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                      input bit flip, input bit stopv, input bit rdy, input bit midcfg);
    logic [7:0]  dm;
    logic        p;
    logic        brk;
    logic [11:0] w;
    dm  = d & 8'((1 << nb) - 1);
    p   = (^dm) ^ podd ^ flip;
    brk = (dm == 8'h00) && (!pen || !p) && !stopv;
    w   = {bench_ovr, brk, flip & pen, !stopv, dm};
    cfg_len = 2'(nb - 5); cfg_par_en = pen; cfg_par_odd = podd; word_ready = rdy;
    if (rdy) begin exp_q.push_back(w); bench_ovr = 1'b0; end
    else bench_ovr = 1'b1;
    rx_in = 1'b0; wclk(BITC);
    if (midcfg) begin cfg_len = ~cfg_len; cfg_par_en = ~cfg_par_en; end
    for (int i = 0; i < nb; i++) begin rx_in = dm[i]; wclk(BITC); end
    if (pen) begin rx_in = p; wclk(BITC); end
    rx_in = stopv; wclk(BITC);
    rx_in = 1'b1;
    chk(exp_q.size() == 0, "R8", "word not delivered by end of stop bit", exp_q.size(), 0);
    wclk(2 * BITC);
    word_ready = 1'b1;
  endtask

  initial begin
    int base;
    wclk(10);
    rst_n = 1'b1;
    wclk(1);
    chk(word_valid == 1'b0, "R10", "valid after reset", int'(word_valid), 0);
    // R1: line low since reset never starts a character
    wclk(3 * BITC);
    chk(n_words == 0, "R1", "word from line low since reset", n_words, 0);
    rx_in = 1'b1; wclk(2 * BITC);
    // R3 / R8: 8 data bits, no parity
    send(8'hA5, 8, 0, 0, 0, 1, 1, 0);
    // R5: 7 bits even parity, correct
    send(8'h4B, 7, 1, 0, 0, 1, 1, 0);
    // R4: 5 bits odd parity, upper bits zero
    send(8'hF3, 5, 1, 1, 0, 1, 1, 0);
    // R4: 6 bits no parity
    send(8'h2A, 6, 0, 0, 0, 1, 1, 0);
    // R5: parity mismatch
    send(8'h3C, 8, 1, 0, 1, 1, 1, 0);
    send(8'h91, 7, 1, 1, 1, 1, 1, 0);
    // R6: low stop bit
    send(8'h81, 8, 0, 0, 0, 0, 1, 0);
    // R2: false start shorter than half a bit
    base = n_words;
    rx_in = 1'b0; wclk(3 * TDIV);
    rx_in = 1'b1; wclk(2 * BITC);
    chk(n_words == base, "R2", "false start produced a word", n_words, base);
    send(8'h66, 8, 0, 0, 0, 1, 1, 0);
    // R7: break with parity bit low
    send(8'h00, 8, 1, 0, 0, 0, 1, 0);
    // R7: long break yields one word and waits for high
    base = n_words;
    cfg_len = 2'd3; cfg_par_en = 1'b0;
    exp_q.push_back(12'h500);
    rx_in = 1'b0; wclk(16 * BITC);
    chk(n_words == base + 1, "R7", "words during held break", n_words, base + 1);
    rx_in = 1'b1; wclk(BITC);
    send(8'hC3, 8, 0, 0, 0, 1, 1, 0);
    // R9: overrun
    send(8'h11, 8, 0, 0, 0, 1, 0, 0);
    send(8'h22, 8, 0, 0, 0, 1, 1, 0);
    send(8'h33, 8, 0, 0, 0, 1, 1, 0);
    // R11: configuration changed mid-character
    send(8'hE7, 8, 0, 0, 0, 1, 1, 1);
    send(8'h0D, 5, 0, 0, 0, 1, 1, 1);
    chk(exp_q.size() == 0, "R8", "words left in scoreboard", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule